// File: doc/BRIEF.md
# Sensor Frame Capture with Header and Row Marker Tagging

This block sits between a parallel-output image sensor and the write side of a dual-clock queue. It runs on the sensor clock, samples a 10-bit pixel on every rising edge while both the frame and line strobes are high, and turns that stream into 9-bit queue words. Bit 8 of each word says whether the word is control metadata (1) or pixel payload (0); bits 7:0 carry the byte.

When a frame strobe rises, the block writes an eight-byte image header. When a row begins, it writes a two-byte row marker. Pixels are then packed bit-serially, least significant bit first, into bytes. Metadata is sent in the idle cycles the sensor leaves before a frame and before each row. A small bit accumulator absorbs the difference between 10 bits arriving and 8 bits leaving per cycle, and it drains during horizontal blanking.

The sensor must leave at least eight idle cycles between the frame strobe rising and the first row. Horizontal blanking must be long enough to drain the previous row. That takes about a quarter of the row's pixel count plus four cycles. Rows may be at most `MAX_LINE_PIX` pixels long.

Top module: `pixel_capture_tagger`

## Requirements
- R1: During reset and on the first cycle after it, `q_wr` and `overflow` are low.
- R2: On a rising frame strobe, eight control words (bit 8 = 1) are written, carrying in order: start code low byte, start code high byte, frame number low byte, frame number high byte, width low byte, width high byte, height low byte, height high byte. Width, height and start code are parameters. The first header word is written on the second clock edge after the first one that samples `frame_valid` high.
- R3: The frame number in the header is 0 for the first frame after reset and rises by one for each later frame.
- R4: On each rising line strobe inside a frame, two control words are written, holding the row index low byte and then its high byte. The row index is 0 for the first row of each frame and rises by one for each row.
- R5: Pixels are packed into data words (bit 8 = 0) little-endian. Pixel bit k of the n-th pixel of a row is stream bit 10n+k, and stream bit 8m+j lands in bit j of data byte m of that row. Four pixels therefore make five bytes.
- R6: When a row's bit count is not a multiple of 8, its last data byte is filled with zeros above the final pixel bit.
- R7: Within a frame, the queue receives the header, then, for each row, that row's marker followed by that row's data bytes, with no other words.
- R8: A word that falls due while `q_full` is high is discarded with `q_wr` low, and `overflow` goes high and stays high until reset.
- R9: `q_wr` is never high in a cycle that follows a clock edge at which `q_full` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_data | input | 10 | Pixel sample |
| frame_valid | input | 1 | Frame strobe from the sensor |
| line_valid | input | 1 | Row strobe from the sensor; pixels are valid while it and frame_valid are high |
| q_full | input | 1 | Queue cannot accept a word |
| q_wr | output | 1 | Queue write enable |
| q_word | output | 9 | Queue word: bit 8 control flag, bits 7:0 byte |
| overflow | output | 1 | Sticky flag: a word was dropped because the queue was full |

## Verification
All results come from registers, so a word that is due after a clock edge shows on `q_wr`/`q_word` for exactly one cycle after that edge. The header starts one edge after the edge that sees the frame strobe rise, and a row's marker is followed by its data starting three edges after the row begins. The bench drives inputs and samples outputs on the falling edge. It records every word written and compares the whole ordered stream against a bit-level packing model, so checks do not depend on cycle-exact alignment of data bytes. The one exact-cycle check is the start of the header, which is sampled on the two falling edges after the frame strobe rises. Overflow and its stickiness are checked at the ports after frames sent with the queue full and then free.

// File: rtl/pixel_capture_tagger.sv
module pixel_capture_tagger #(
  parameter int          PIX_BITS     = 10,
  parameter int          MAX_LINE_PIX = 64,
  parameter logic [15:0] FRAME_WIDTH  = 16'd64,
  parameter logic [15:0] FRAME_HEIGHT = 16'd16,
  parameter logic [15:0] START_CODE   = 16'hC35A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PIX_BITS-1:0] px_data,
  input  logic                frame_valid,
  input  logic                line_valid,
  input  logic                q_full,
  output logic                q_wr,
  output logic [8:0]          q_word,
  output logic                overflow
);
  localparam int ACC_W = (PIX_BITS - 8) * MAX_LINE_PIX + 48;
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic             fv_q, lv_q;
  logic [3:0]       hdr_left;
  logic [1:0]       mk_left;
  logic [15:0]      frame_cnt, hdr_frame, line_idx, mk_val;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;

  wire px_in      = frame_valid & line_valid;
  wire frame_rise = frame_valid & ~fv_q;
  wire line_rise  = px_in & ~lv_q;
  wire line_end   = lv_q & ~px_in;

  wire take_hdr = hdr_left != 4'd0;
  wire take_mk  = !take_hdr && mk_left != 2'd0;
  wire take_px  = !take_hdr && !take_mk && cnt >= CNT_W'(8);
  wire emit     = take_hdr | take_mk | take_px;

  wire [63:0] hdr_bits = {FRAME_HEIGHT, FRAME_WIDTH, hdr_frame, START_CODE};
  wire [3:0]  hdr_off  = 4'd8 - hdr_left;
  wire [7:0]  hdr_byte = hdr_bits[{hdr_off[2:0], 3'b000} +: 8];
  wire [7:0]  mk_byte  = (mk_left == 2'd2) ? mk_val[7:0] : mk_val[15:8];

  logic [8:0] emit_word;
  always_comb begin
    if (take_hdr)     emit_word = {1'b1, hdr_byte};
    else if (take_mk) emit_word = {1'b1, mk_byte};
    else              emit_word = {1'b0, acc[7:0]};
  end

  wire [CNT_W-1:0] cnt_after = take_px ? cnt - CNT_W'(8) : cnt;
  wire [ACC_W-1:0] acc_after = take_px ? (acc >> 8) : acc;
  wire [ACC_W-1:0] acc_ins   = px_in ? (acc_after | (ACC_W'(px_data) << cnt_after)) : acc_after;
  wire [CNT_W-1:0] cnt_ins   = px_in ? cnt_after + CNT_W'(PIX_BITS) : cnt_after;
  wire [CNT_W-1:0] cnt_pad   = (cnt_ins + CNT_W'(7)) & ~CNT_W'(7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q      <= 1'b0;
      lv_q      <= 1'b0;
      hdr_left  <= '0;
      mk_left   <= '0;
      frame_cnt <= '0;
      hdr_frame <= '0;
      line_idx  <= '0;
      mk_val    <= '0;
      acc       <= '0;
      cnt       <= '0;
      q_wr      <= 1'b0;
      q_word    <= '0;
      overflow  <= 1'b0;
    end else begin
      fv_q <= frame_valid;
      lv_q <= px_in;

      q_wr <= emit & ~q_full;
      if (emit & ~q_full) q_word <= emit_word;
      if (emit & q_full)  overflow <= 1'b1;

      if (frame_rise) begin
        hdr_left  <= 4'd8;
        hdr_frame <= frame_cnt;
        frame_cnt <= frame_cnt + 16'd1;
      end else if (take_hdr) begin
        hdr_left <= hdr_left - 4'd1;
      end

      if (line_rise) begin
        mk_left  <= 2'd2;
        mk_val   <= frame_rise ? 16'd0 : line_idx;
        line_idx <= frame_rise ? 16'd1 : line_idx + 16'd1;
      end else begin
        if (take_mk)    mk_left  <= mk_left - 2'd1;
        if (frame_rise) line_idx <= 16'd0;
      end

      acc <= acc_ins;
      cnt <= line_end ? cnt_pad : cnt_ins;
    end
  end
endmodule

// File: rtl/pixel_capture_tagger_checks.sv
module pixel_capture_tagger_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_valid,
  input logic       q_full,
  input logic       q_wr,
  input logic [8:0] q_word,
  input logic       overflow
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!q_wr && !overflow));

  assert_header_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) ##1 !q_full |=> (q_wr && q_word[8]));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_overflow_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(q_full));

  assert_no_write_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_wr |-> !$past(q_full));
endmodule

bind pixel_capture_tagger pixel_capture_tagger_checks u_checks (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .q_full(q_full),
  .q_wr(q_wr), .q_word(q_word), .overflow(overflow)
);

// File: tb/pixel_capture_tagger_bench.sv
module pixel_capture_tagger_bench;
  localparam logic [15:0] W_HDR = 16'h0140;
  localparam logic [15:0] H_HDR = 16'h00F0;
  localparam logic [15:0] CODE  = 16'hC35A;
  // rows: lines, pixels per line, seed
  localparam int VEC [4][3] = '{'{2, 8, 1}, '{3, 5, 7}, '{1, 64, 3}, '{2, 1, 9}};

  logic clk = 0, rst_n = 0, frame_valid = 0, line_valid = 0, q_full = 0;
  logic [9:0] px_data = '0;
  wire q_wr, overflow;
  wire [8:0] q_word;

  pixel_capture_tagger #(.PIX_BITS(10), .MAX_LINE_PIX(64), .FRAME_WIDTH(W_HDR),
    .FRAME_HEIGHT(H_HDR), .START_CODE(CODE)) u_pixel_capture_tagger (
    .clk(clk), .rst_n(rst_n), .px_data(px_data), .frame_valid(frame_valid),
    .line_valid(line_valid), .q_full(q_full), .q_wr(q_wr), .q_word(q_word),
    .overflow(overflow));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [8:0] got [0:511];
  logic [8:0] expw [0:511];
  int expt [0:511];
  int n_got = 0, n_exp = 0;
  int frame_no = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n && q_wr && n_got < 512) begin
    got[n_got] = q_word;
    n_got++;
  end

  function automatic string tagname(int t);
    case (t)
      2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] pix_val(int seed, int l, int p);
    return 10'((seed * 97 + l * 31 + p * 53) ^ (p << 5) ^ (seed << 8));
  endfunction

  task automatic push(logic [8:0] w, int t);
    expw[n_exp] = w;
    expt[n_exp] = t;
    n_exp++;
  endtask

  task automatic build_expected(int lines, int pix, int seed, int fno);
    logic bits [0:1023];
    int nb, nbytes;
    logic [7:0] b;
    push({1'b1, CODE[7:0]}, 2);  push({1'b1, CODE[15:8]}, 2);
    push({1'b1, 8'(fno)}, 3);    push({1'b1, 8'(fno >> 8)}, 3);
    push({1'b1, W_HDR[7:0]}, 2); push({1'b1, W_HDR[15:8]}, 2);
    push({1'b1, H_HDR[7:0]}, 2); push({1'b1, H_HDR[15:8]}, 2);
    for (int l = 0; l < lines; l++) begin
      push({1'b1, 8'(l)}, 4);
      push({1'b1, 8'(l >> 8)}, 4);
      nb = 0;
      for (int p = 0; p < pix; p++) begin
        logic [9:0] v;
        v = pix_val(seed, l, p);
        for (int k = 0; k < 10; k++) begin bits[nb] = v[k]; nb++; end
      end
      nbytes = (nb + 7) / 8;
      for (int m = 0; m < nbytes; m++) begin
        for (int j = 0; j < 8; j++) b[j] = (8 * m + j < nb) ? bits[8 * m + j] : 1'b0;
        push({1'b0, b}, (m == nbytes - 1 && nb % 8 != 0) ? 6 : 5);
      end
    end
  endtask

  task automatic drive_frame(int lines, int pix, int seed, bit do_t);
    @(negedge clk);
    frame_valid = 1;
    @(negedge clk);
    if (do_t) chk(!q_wr, "R2 header not before second edge", int'(q_wr), 0);
    @(negedge clk);
    if (do_t) chk(q_wr && q_word == {1'b1, CODE[7:0]}, "R2 first header word timing",
                  int'({q_wr, q_word}), int'({1'b1, 1'b1, CODE[7:0]}));
    repeat (10) @(negedge clk);
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < pix; p++) begin
        line_valid = 1;
        px_data = pix_val(seed, l, p);
        @(negedge clk);
      end
      line_valid = 0;
      px_data = '0;
      repeat (pix / 2 + 12) @(negedge clk);
    end
    frame_valid = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic compare_stream();
    int n;
    chk(n_got == n_exp, "R7 word count", n_got, n_exp);
    n = (n_got < n_exp) ? n_got : n_exp;
    for (int i = 0; i < n; i++)
      chk(got[i] === expw[i], tagname(expt[i]), int'(got[i]), int'(expw[i]));
    n_got = 0;
    n_exp = 0;
  endtask

  task automatic run_frame(int lines, int pix, int seed, bit do_t);
    build_expected(lines, pix, seed, frame_no);
    drive_frame(lines, pix, seed, do_t);
    frame_no++;
    compare_stream();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!q_wr && !overflow, "R1 in reset", int'({q_wr, overflow}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!q_wr && !overflow, "R1 after reset", int'({q_wr, overflow}), 0);

    for (int v = 0; v < 4; v++) run_frame(VEC[v][0], VEC[v][1], VEC[v][2], v == 0);

    // R2 timing again on a later frame, four-pixel row = five bytes (R5)
    run_frame(1, 4, 5, 1);

    // R8: queue full drops everything and sets the sticky flag
    @(negedge clk);
    q_full = 1;
    drive_frame(1, 4, 11, 0);
    frame_no++;
    chk(n_got == 0, "R8 no words written while full", n_got, 0);
    chk(overflow, "R8 overflow set", int'(overflow), 1);
    n_got = 0;
    q_full = 0;
    run_frame(2, 6, 13, 0);
    chk(overflow, "R8 overflow sticky", int'(overflow), 1);

    // reset clears flag and frame numbering (R1, R3)
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!overflow && !q_wr, "R1 reset clears overflow", int'({q_wr, overflow}), 0);
    rst_n = 1;
    n_got = 0;
    frame_no = 0;
    run_frame(1, 3, 4, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule